// File: doc/BRIEF.md
# Iterative SHA-1 Compression Core

This block applies the SHA-1 compression function to one 512-bit message block at a time and carries the 160-bit chaining value from block to block. A host hands over a block that is already padded and length-encoded, together with a one-cycle start pulse. An init pulse begins a new message from the standard initial hash value. A next pulse continues the current message from the digest of the previous block. The core runs one round per clock. A fixed number of cycles later it raises a digest-valid flag and is ready for the next block.

The rounds do not use an 80-word expanded schedule. A sixteen-word register window slides by one word each round. The oldest word feeds the round, and a new word is computed from four window taps and shifted in at the far end. Each block goes through three phases: one cycle copies the chaining value into the working registers, eighty cycles run the rounds, and one cycle adds the working words back into the chaining value.

Top module: `sha1_iter_core`

## Requirements
- R1: After reset, `ready_o` is 1, `digest_valid_o` is 0 and `digest_o` is all zeros.
- R2: A start pulse (`init_i` or `next_i` high) that is sampled at a clock edge while `ready_o` is 1 is accepted. After that edge `ready_o` is 0 and `digest_valid_o` is 0.
- R3: For an accepted block, `digest_valid_o` and `ready_o` both become 1 exactly 82 clock edges after the accepting edge, and not before.
- R4: An init on the single padded block for "abc" (word 0 = 61626380, word 15 = 00000018, every other word zero, word 0 in bits 511:480) produces the digest A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D. The first word is in bits 159:128.
- R5: After an init on the first block of the padded 56-byte test message, a next on its second block produces 84983E44 1C3BD26E BAAE4AA1 F95129E5 E54670F1. For any block sequence, every digest equals the SHA-1 compression of the previous chaining value and the block.
- R6: Start pulses that arrive while `ready_o` is 0 are ignored. Neither the timing nor the digest of the block in flight changes.
- R7: While the core is idle and no start pulse is present, `digest_o` holds its value.
- R8: If `init_i` and `next_i` are high in the same accepting cycle, init wins and the chaining value restarts from the initial hash value.
- R9: An init after a chained sequence ignores the earlier digest. The result depends only on the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Start a new message with this block |
| next_i | input | 1 | Continue the current message with this block |
| block_i | input | 512 | Padded message block, word 0 in the top bits |
| ready_o | output | 1 | Core idle and able to accept a block |
| digest_o | output | 160 | Chaining value / digest, word A in the top bits |
| digest_valid_o | output | 1 | Digest of the last accepted block is available |

## Verification
Any fault in the working registers, the schedule window or the round selection is invisible until the finalize cycle. It then shows at the ports as a digest that differs from the reference, 82 edges after the block was accepted. A fault in the chaining register may show only one block later, so chained sequences are checked block by block. A fault in the round counter or the phase sequencing moves the rise of `ready_o` and `digest_valid_o`. The cycle-by-cycle handshake comparison catches it on the first cycle that is wrong.

// File: rtl/sha1_pkg.sv
package sha1_pkg;

  localparam int WORD_W    = 32;
  localparam int N_ROUNDS  = 80;
  localparam int WIN_WORDS = 16;
  localparam int ROUND_W   = $clog2(N_ROUNDS + 1);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } hstate_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_ROUND = 2'd2,
    ST_FIN   = 2'd3
  } phase_t;

  localparam hstate_t SHA1_IV = '{
    a: 32'h67452301,
    b: 32'hEFCDAB89,
    c: 32'h98BADCFE,
    d: 32'h10325476,
    e: 32'hC3D2E1F0
  };

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t round_k(input logic [ROUND_W-1:0] t);
    if (t < ROUND_W'(20))      return 32'h5A827999;
    else if (t < ROUND_W'(40)) return 32'h6ED9EBA1;
    else if (t < ROUND_W'(60)) return 32'h8F1BBCDC;
    else                       return 32'hCA62C1D6;
  endfunction

  function automatic word_t round_f(input logic [ROUND_W-1:0] t,
                                    input word_t b, input word_t c, input word_t d);
    if (t < ROUND_W'(20))      return (b & c) | (~b & d);
    else if (t < ROUND_W'(40)) return b ^ c ^ d;
    else if (t < ROUND_W'(60)) return (b & c) | (b & d) | (c & d);
    else                       return b ^ c ^ d;
  endfunction

endpackage

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
  import sha1_pkg::*;
#(
  parameter int ROUNDS = N_ROUNDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               accept_o,
  output logic               load_o,
  output logic               round_o,
  output logic               fin_o,
  output logic               ready_o,
  output logic               valid_o,
  output logic [ROUND_W-1:0] rnd_o
);

  localparam logic [ROUND_W-1:0] LAST_RND = ROUND_W'(ROUNDS - 1);

  phase_t             phase_q, phase_d;
  logic [ROUND_W-1:0] rnd_q, rnd_d;
  logic               valid_q, valid_d;

  assign ready_o  = (phase_q == ST_IDLE);
  assign accept_o = ready_o && start_i;
  assign load_o   = (phase_q == ST_LOAD);
  assign round_o  = (phase_q == ST_ROUND);
  assign fin_o    = (phase_q == ST_FIN);
  assign valid_o  = valid_q;
  assign rnd_o    = rnd_q;

  always_comb begin
    phase_d = phase_q;
    rnd_d   = rnd_q;
    valid_d = valid_q;
    unique case (phase_q)
      ST_IDLE: begin
        if (start_i) begin
          phase_d = ST_LOAD;
          valid_d = 1'b0;
        end
      end
      ST_LOAD: begin
        phase_d = ST_ROUND;
        rnd_d   = '0;
      end
      ST_ROUND: begin
        rnd_d = rnd_q + ROUND_W'(1);
        if (rnd_q == LAST_RND) phase_d = ST_FIN;
      end
      ST_FIN: begin
        phase_d = ST_IDLE;
        valid_d = 1'b1;
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      rnd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rnd_q   <= rnd_d;
      valid_q <= valid_d;
    end
  end

endmodule

// File: rtl/sha1_sched.sv
module sha1_sched
  import sha1_pkg::*;
#(
  parameter int WORDS = WIN_WORDS,
  parameter int WW    = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORDS*WW-1:0] block_i,
  output logic [WW-1:0]     cur_o
);

  localparam int TAP_A = WORDS - 3;
  localparam int TAP_B = WORDS - 8;
  localparam int TAP_C = WORDS - 14;
  localparam int TAP_D = 0;

  logic [WW-1:0] win_q [WORDS];
  logic [WW-1:0] fresh;

  assign fresh = rotl(win_q[TAP_A] ^ win_q[TAP_B] ^ win_q[TAP_C] ^ win_q[TAP_D], 1);
  assign cur_o = win_q[0];

  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    logic [WW-1:0] slot_d;
    logic [WW-1:0] upstream;

    if (i == WORDS - 1) begin : g_tail
      assign upstream = fresh;
    end else begin : g_body
      assign upstream = win_q[i+1];
    end

    always_comb begin
      slot_d = win_q[i];
      if (load_i)       slot_d = block_i[(WORDS-1-i)*WW +: WW];
      else if (shift_i) slot_d = upstream;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q[i] <= '0;
      else        win_q[i] <= slot_d;
    end
  end

endmodule

// File: rtl/sha1_round.sv
module sha1_round
  import sha1_pkg::*;
(
  input  hstate_t            cur_i,
  input  word_t              w_i,
  input  logic [ROUND_W-1:0] t_i,
  output hstate_t            nxt_o
);

  word_t temp;

  always_comb begin
    temp = rotl(cur_i.a, 5) + round_f(t_i, cur_i.b, cur_i.c, cur_i.d)
         + cur_i.e + round_k(t_i) + w_i;
    nxt_o.a = temp;
    nxt_o.b = cur_i.a;
    nxt_o.c = rotl(cur_i.b, 30);
    nxt_o.d = cur_i.c;
    nxt_o.e = cur_i.d;
  end

endmodule

// File: rtl/sha1_iter_core.sv
module sha1_iter_core
  import sha1_pkg::*;
#(
  parameter int ROUNDS = N_ROUNDS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         next_i,
  input  logic [511:0] block_i,
  output logic         ready_o,
  output logic [159:0] digest_o,
  output logic         digest_valid_o
);

  logic               accept, load_en, round_en, fin_en;
  logic [ROUND_W-1:0] rnd;
  word_t              w_cur;
  hstate_t            chain_q, chain_d;
  hstate_t            work_q, work_d;
  hstate_t            work_nxt;

  sha1_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (init_i | next_i),
    .accept_o(accept),
    .load_o  (load_en),
    .round_o (round_en),
    .fin_o   (fin_en),
    .ready_o (ready_o),
    .valid_o (digest_valid_o),
    .rnd_o   (rnd)
  );

  sha1_sched #(.WORDS(WIN_WORDS), .WW(WORD_W)) u_sched (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .shift_i(round_en),
    .block_i(block_i),
    .cur_o  (w_cur)
  );

  sha1_round u_round (
    .cur_i(work_q),
    .w_i  (w_cur),
    .t_i  (rnd),
    .nxt_o(work_nxt)
  );

  always_comb begin
    chain_d = chain_q;
    if (accept && init_i) begin
      chain_d = SHA1_IV;
    end else if (fin_en) begin
      chain_d.a = chain_q.a + work_q.a;
      chain_d.b = chain_q.b + work_q.b;
      chain_d.c = chain_q.c + work_q.c;
      chain_d.d = chain_q.d + work_q.d;
      chain_d.e = chain_q.e + work_q.e;
    end
  end

  always_comb begin
    work_d = work_q;
    if (load_en)       work_d = chain_q;
    else if (round_en) work_d = work_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      work_q  <= '0;
    end else begin
      chain_q <= chain_d;
      work_q  <= work_d;
    end
  end

  assign digest_o = chain_q;

endmodule

// File: rtl/sha1_iter_core_chk.sv
module sha1_iter_core_chk #(
  parameter int ROUNDS = 80
) (
  input logic         clk,
  input logic         rst_n,
  input logic         init_i,
  input logic         next_i,
  input logic         ready_o,
  input logic [159:0] digest_o,
  input logic         digest_valid_o
);

  localparam int LAT  = ROUNDS + 2;
  localparam int CW   = $clog2(LAT + 2);
  localparam logic [159:0] IV_FLAT =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  logic [CW-1:0] lat_cnt;
  logic          take;

  assign take = ready_o && (init_i || next_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                lat_cnt <= '0;
    else if (take)                             lat_cnt <= CW'(1);
    else if (!ready_o && lat_cnt != CW'(LAT))  lat_cnt <= lat_cnt + CW'(1);
  end

  // R2: accepted start drops ready and valid
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!ready_o && !digest_valid_o));

  // R3: ready returns after exactly the fixed latency
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (lat_cnt == CW'(LAT)));

  // R3: valid rises together with ready
  p_valid_with_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digest_valid_o) |-> ready_o);

  // R6: busy core ignores start pulses
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && (init_i || next_i) && lat_cnt < CW'(LAT - 1)) |=> !ready_o);

  // R7: idle digest is held
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !init_i && !next_i) |=> $stable(digest_o));

  // R8: init restarts the chaining value
  p_init_iv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && init_i) |=> (digest_o == IV_FLAT));

endmodule

bind sha1_iter_core sha1_iter_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init_i        (init_i),
  .next_i        (next_i),
  .ready_o       (ready_o),
  .digest_o      (digest_o),
  .digest_valid_o(digest_valid_o)
);

// File: tb/tb_sha1_iter_core.sv
module tb_sha1_iter_core;

  localparam int CLK_PERIOD = 10;
  localparam logic [159:0] IV_FLAT = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [159:0] KAT_ABC = 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D;
  localparam logic [159:0] KAT_TWO = 160'h84983E44_1C3BD26E_BAAE4AA1_F95129E5_E54670F1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init_i = 1'b0;
  logic         next_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         ready_o;
  logic [159:0] digest_o;
  logic         digest_valid_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha1_iter_core dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
    .block_i(block_i), .ready_o(ready_o), .digest_o(digest_o),
    .digest_valid_o(digest_valid_o)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_comp(input logic [159:0] h, input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] v [5];
    logic [31:0] f, k, tmp;
    for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    for (int j = 0; j < 5; j++) v[j] = h[159 - 32*j -: 32];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (v[1] & v[2]) | (~v[1] & v[3]); k = 32'h5A827999; end
      else if (i < 40) begin f = v[1] ^ v[2] ^ v[3]; k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (v[1] & v[2]) | (v[1] & v[3]) | (v[2] & v[3]); k = 32'h8F1BBCDC; end
      else             begin f = v[1] ^ v[2] ^ v[3]; k = 32'hCA62C1D6; end
      tmp  = rl(v[0], 5) + f + v[4] + k + w[i];
      v[4] = v[3];
      v[3] = v[2];
      v[2] = rl(v[1], 30);
      v[1] = v[0];
      v[0] = tmp;
    end
    for (int j = 0; j < 5; j++) h[159 - 32*j -: 32] = h[159 - 32*j -: 32] + v[j];
    return h;
  endfunction

  // reference model, advanced on every rising edge
  bit           m_ready = 1'b1;
  bit           m_valid = 1'b0;
  int           m_cnt = 0;
  logic [159:0] m_chain = '0;
  logic [511:0] m_blk = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 1'b1; m_valid = 1'b0; m_cnt = 0; m_chain = '0;
    end else if (m_ready && (init_i || next_i)) begin
      m_ready = 1'b0; m_valid = 1'b0; m_cnt = 0; m_blk = block_i;
      if (init_i) m_chain = IV_FLAT;
    end else if (!m_ready) begin
      m_cnt++;
      if (m_cnt == 82) begin
        m_chain = ref_comp(m_chain, m_blk);
        m_ready = 1'b1;
        m_valid = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ready_o == m_ready, "R3 ready vs model", 160'(ready_o), 160'(m_ready));
      check(digest_valid_o == m_valid, "R2 valid vs model", 160'(digest_valid_o), 160'(m_valid));
      if (m_valid) check(digest_o == m_chain, "R5 digest vs model", digest_o, m_chain);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic start(input bit use_init, input bit use_next, input logic [511:0] blk);
    @(negedge clk);
    init_i = use_init; next_i = use_next; block_i = blk;
    @(negedge clk);
    init_i = 1'b0; next_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!digest_valid_o) begin
      @(negedge clk);
      lat++;
    end
  endtask

  logic [511:0] blk_abc, blk_m1, blk_m2;

  initial begin
    blk_abc = '0;
    blk_abc[511:480] = 32'h61626380;
    blk_abc[31:0]    = 32'h00000018;
    blk_m1 = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
              32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
              32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
              32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    blk_m2 = '0;
    blk_m2[31:0] = 32'h000001C0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lat;
    logic [159:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ready_o && !digest_valid_o, "R1 idle after reset", {ready_o, digest_valid_o}, 2'b10);
    check(digest_o == '0, "R1 digest cleared", digest_o, '0);

    // R2, R3, R4: single block
    start(1'b1, 1'b0, blk_abc);
    check(!ready_o && !digest_valid_o, "R2 busy after accept", {ready_o, digest_valid_o}, 2'b00);
    wait_done(lat);
    check(lat == 82, "R3 latency", 160'(lat), 160'd82);
    check(ready_o, "R3 ready with valid", 160'(ready_o), 160'd1);
    check(digest_o == KAT_ABC, "R4 abc digest", digest_o, KAT_ABC);

    // R7: idle hold
    held = digest_o;
    repeat (6) @(negedge clk);
    check(digest_o == held, "R7 idle hold", digest_o, held);

    // R5: two-block chaining
    start(1'b1, 1'b0, blk_m1);
    wait_done(lat);
    check(digest_o == ref_comp(IV_FLAT, blk_m1), "R5 first block", digest_o, ref_comp(IV_FLAT, blk_m1));
    start(1'b0, 1'b1, blk_m2);
    wait_done(lat);
    check(digest_o == KAT_TWO, "R5 chained digest", digest_o, KAT_TWO);

    // R9: init after chaining restarts
    start(1'b1, 1'b0, blk_abc);
    wait_done(lat);
    check(digest_o == KAT_ABC, "R9 restart after chain", digest_o, KAT_ABC);

    // R8: init and next together, init wins
    start(1'b1, 1'b0, blk_m1);
    wait_done(lat);
    start(1'b1, 1'b1, blk_abc);
    wait_done(lat);
    check(digest_o == KAT_ABC, "R8 init priority", digest_o, KAT_ABC);

    // R6: pulses while busy ignored
    start(1'b1, 1'b0, blk_m1);
    repeat (10) @(negedge clk);
    next_i = 1'b1; block_i = blk_abc;
    @(negedge clk);
    next_i = 1'b0;
    repeat (30) @(negedge clk);
    init_i = 1'b1; block_i = blk_m2;
    @(negedge clk);
    init_i = 1'b0;
    lat = 42;
    while (!digest_valid_o) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 82, "R6 latency unchanged", 160'(lat), 160'd82);
    check(digest_o == ref_comp(IV_FLAT, blk_m1), "R6 digest unchanged", digest_o, ref_comp(IV_FLAT, blk_m1));
    start(1'b0, 1'b1, blk_m2);
    wait_done(lat);
    check(digest_o == KAT_TWO, "R6 chain intact", digest_o, KAT_TWO);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule